// File: doc/BRIEF.md
# Stereo Bridge Output Power-State and Protection Controller

This block is the digital control core for a two-channel bridge-tied switching output stage. Each channel has a positive and a negative leg, and each leg has its own ready-made pulse-width stream. The block passes those four streams to the output drivers or holds them low. It also decides when the stage is running, when it is silenced, and when it raises a warning to the system.

A shutdown input puts the stage into its lowest-power state. A silence input holds the drivers low. Comparators report overcurrent and die over-temperature, and a monitor reports supply faults, meaning brown-out or a sudden step in the supply. After reset, after shutdown is released, and after a supply fault clears, the drivers stay low for a settling window. The length of that window is picked from four values that match the reference capacitor fitted on the board.

The single warning output is the OR of two conditions. The overcurrent warning is sticky, and only a full low-high-low cycle of the shutdown input or a reset clears it. The thermal warning follows the temperature flag and clears itself. All control and fault inputs are asynchronous and pass through two-flop synchronizers.

Top module: `amp_power_guard`

## Requirements
- R1: While the synchronized shutdown input is high, all four driver outputs are low, the warning output is low, and fault flags raised during shutdown set no warning.
- R2: While the synchronized silence input is high, all four driver outputs are low. Otherwise, once the settling window has ended, `drv_out[i]` equals `pwm_in[i]`. Bit 0 is left plus, bit 1 is left minus, bit 2 is right plus and bit 3 is right minus.
- R3: An overcurrent flag seen while the drivers are silenced sets no warning.
- R4: `prot_out` is high when the sticky overcurrent warning or the thermal warning is set, except during shutdown.
- R5: Once set, the overcurrent warning stays set after the flag drops, including while silenced. It clears only when the shutdown input goes high and then low again, or on reset.
- R6: The thermal warning drops within a few cycles of the temperature flag going low. It needs no other action to clear.
- R7: The drivers stay low for a settling window after reset is released and after shutdown is released. `start_sel` 0, 1, 2 and 3 give 130 ms, 330 ms, 850 ms and 1400 ms, counted as `CLK_HZ*ms/1000` clock cycles, with a tolerance of a few cycles for synchronization.
- R8: While `supply_fault` is high the drivers are low and no fault is qualified. When it drops, a full settling window runs again before the drivers resume.
- R9: Fault flags raised during a settling window, such as a short glitch just after wake-up, set no warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, acts as power-on reset |
| sleep_req | input | 1 | Shutdown request, asynchronous |
| mute_req | input | 1 | Silence request, asynchronous |
| oc_flag | input | 1 | Overcurrent comparator flag, asynchronous |
| ot_flag | input | 1 | Over-temperature comparator flag, asynchronous |
| supply_fault | input | 1 | Brown-out or supply-step flag, asynchronous |
| start_sel | input | 2 | Settling window select |
| pwm_in | input | 4 | Pulse streams: L+, L-, R+, R- |
| drv_out | output | 4 | Gated driver outputs, same bit order |
| prot_out | output | 1 | Combined warning |

## Verification
The bench targets several corner cases:
- It holds the overcurrent flag while silenced. A design that failed to suppress it would raise a warning there.
- It drops the overcurrent flag and checks that the warning stays. A design that auto-cleared it would lose the warning.
- It pulses both fault flags inside the settling window that follows wake-up. A design that qualified faults too early would report the wake-up glitch.
- It samples each of the four settling windows a few cycles before and after the computed end. A wrong table entry, or a window that does not restart after a supply fault, unmutes at the wrong time.
- It drives distinct patterns through the outputs, so any swapped legs show up.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE     = 2'd0,
    TRK_SAW_HIGH = 2'd1,
    TRK_CLEARED  = 2'd2
  } trk_state_t;

  // settling window in milliseconds for each capacitor choice
  function automatic logic [31:0] start_ms(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd130;
      2'd1:    return 32'd330;
      2'd2:    return 32'd850;
      default: return 32'd1400;
    endcase
  endfunction

  // window length in clock cycles
  function automatic logic [63:0] start_cycles(input logic [1:0] sel,
                                               input logic [63:0] clk_hz);
    logic [63:0] prod;
    prod = clk_hz * {32'd0, start_ms(sel)};
    return prod / 64'd1000;
  endfunction

endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/amp_sleep_track.sv
module amp_sleep_track
  import amp_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_s,
  output logic clear_pulse
);
  trk_state_t state_q, state_d;
  logic       clr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TRK_IDLE:     if (sleep_s)  state_d = TRK_SAW_HIGH;
      TRK_SAW_HIGH: if (!sleep_s) state_d = TRK_CLEARED;
      TRK_CLEARED:  if (sleep_s)  state_d = TRK_SAW_HIGH;
      default:                    state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= (state_q == TRK_SAW_HIGH) && !sleep_s;
    end
  end

  assign clear_pulse = clr_q;
endmodule

// File: rtl/amp_start_timer.sv
module amp_start_timer
  import amp_guard_pkg::*;
#(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int          CNT_W  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] sel,
  output logic       expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             boot_q;

  assign load_val = CNT_W'(start_cycles(sel, 64'(CLK_HZ)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      boot_q <= 1'b0;
      if (boot_q || hold)
        cnt_q <= load_val;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = !boot_q && !hold && (cnt_q == '0);
endmodule

// File: rtl/amp_fault_unit.sv
module amp_fault_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic started,
  input  logic mute_s,
  input  logic sleep_s,
  input  logic oc_s,
  input  logic ot_s,
  input  logic oc_clear,
  output logic oc_latch,
  output logic therm_warn,
  output logic prot
);
  logic oc_qual;

  assign oc_qual = started && !mute_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_latch   <= 1'b0;
      therm_warn <= 1'b0;
    end else begin
      if (oc_clear)
        oc_latch <= 1'b0;
      else if (oc_qual && oc_s)
        oc_latch <= 1'b1;
      therm_warn <= started && ot_s;
    end
  end

  assign prot = !sleep_s && (oc_latch || therm_warn);
endmodule

// File: rtl/amp_out_gate.sv
module amp_out_gate #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             started,
  input  logic             mute_s,
  input  logic [N_OUT-1:0] pwm,
  output logic [N_OUT-1:0] drv
);
  logic drive_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_en_q <= 1'b0;
    else        drive_en_q <= started && !mute_s;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_leg
    assign drv[i] = pwm[i] & drive_en_q;
  end
endmodule

// File: rtl/amp_power_guard.sv
module amp_power_guard #(
  parameter int unsigned CLK_HZ = 250_000_000,
  parameter int          CNT_W  = 32,
  parameter int          N_CH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              mute_req,
  input  logic              oc_flag,
  input  logic              ot_flag,
  input  logic              supply_fault,
  input  logic [1:0]        start_sel,
  input  logic [2*N_CH-1:0] pwm_in,
  output logic [2*N_CH-1:0] drv_out,
  output logic              prot_out
);
  localparam int N_OUT  = 2 * N_CH;
  localparam int N_SYNC = 5;

  logic [N_SYNC-1:0] raw_in, sync_out;
  logic sleep_s, mute_s, oc_s, ot_s, sup_s;
  logic started, oc_clear, oc_latch, therm_warn;

  assign raw_in = {supply_fault, ot_flag, oc_flag, mute_req, sleep_req};

  amp_sync #(.W(N_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  assign sleep_s = sync_out[0];
  assign mute_s  = sync_out[1];
  assign oc_s    = sync_out[2];
  assign ot_s    = sync_out[3];
  assign sup_s   = sync_out[4];

  amp_sleep_track u_track (
    .clk(clk), .rst_n(rst_n), .sleep_s(sleep_s), .clear_pulse(oc_clear)
  );

  amp_start_timer #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(sleep_s || sup_s),
    .sel(start_sel), .expired(started)
  );

  amp_fault_unit u_fault (
    .clk(clk), .rst_n(rst_n), .started(started), .mute_s(mute_s),
    .sleep_s(sleep_s), .oc_s(oc_s), .ot_s(ot_s), .oc_clear(oc_clear),
    .oc_latch(oc_latch), .therm_warn(therm_warn), .prot(prot_out)
  );

  amp_out_gate #(.N_OUT(N_OUT)) u_gate (
    .clk(clk), .rst_n(rst_n), .started(started), .mute_s(mute_s),
    .pwm(pwm_in), .drv(drv_out)
  );
endmodule

// File: rtl/amp_power_guard_chk.sv
module amp_power_guard_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_s,
  input logic             mute_s,
  input logic             ot_s,
  input logic             sup_s,
  input logic             started,
  input logic             oc_clear,
  input logic             oc_latch,
  input logic             therm_warn,
  input logic [N_OUT-1:0] drv_out,
  input logic             prot_out
);
  p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_s && $past(sleep_s) |-> (drv_out == '0) && !prot_out);

  p_mute_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mute_s && $past(mute_s) |-> drv_out == '0);

  p_oc_muted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_latch) |-> !$past(mute_s) && !$past(sleep_s));

  p_oc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oc_latch && !oc_clear |=> oc_latch);

  p_therm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ot_s |=> !therm_warn);

  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> drv_out == '0);

  p_supply_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sup_s |=> drv_out == '0);

  p_window_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !therm_warn);
endmodule

bind amp_power_guard amp_power_guard_chk #(.N_OUT(2 * N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_s(sleep_s), .mute_s(mute_s),
  .ot_s(ot_s), .sup_s(sup_s), .started(started), .oc_clear(oc_clear),
  .oc_latch(oc_latch), .therm_warn(therm_warn), .drv_out(drv_out),
  .prot_out(prot_out)
);

// File: tb/amp_power_guard_bench.sv
module amp_power_guard_bench;
  localparam int unsigned TB_HZ = 10_000;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, mute_req = 0, oc_flag = 0, ot_flag = 0, supply_fault = 0;
  logic [1:0] start_sel = 2'd0;
  logic [3:0] pwm_in = 4'b1111;
  logic [3:0] drv_out;
  logic       prot_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  amp_power_guard #(.CLK_HZ(TB_HZ), .CNT_W(32), .N_CH(2)) u_amp_power_guard (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mute_req(mute_req),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .supply_fault(supply_fault),
    .start_sel(start_sel), .pwm_in(pwm_in), .drv_out(drv_out), .prot_out(prot_out)
  );

  // vector: mute, oc, ot, pwm[3:0], expected drv[3:0], expected prot
  localparam logic [11:0] VEC [NV] = '{
    {3'b000, 4'b1010, 4'b1010, 1'b0},
    {3'b000, 4'b0101, 4'b0101, 1'b0},
    {3'b100, 4'b1111, 4'b0000, 1'b0},
    {3'b110, 4'b1111, 4'b0000, 1'b0},
    {3'b101, 4'b1111, 4'b0000, 1'b1},
    {3'b000, 4'b0110, 4'b0110, 1'b0},
    {3'b010, 4'b1001, 4'b1001, 1'b1},
    {3'b000, 4'b0011, 4'b0011, 1'b1},
    {3'b100, 4'b1111, 4'b0000, 1'b1},
    {3'b001, 4'b1100, 4'b1100, 1'b1},
    {3'b000, 4'b0001, 4'b0001, 1'b1}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R2", "R3", "R4", "R6",
                                  "R4", "R5", "R5", "R4", "R5"};

  function automatic int window(input logic [1:0] sel);
    int ms;
    ms = (sel == 2'd0) ? 130 : (sel == 2'd1) ? 330 : (sel == 2'd2) ? 850 : 1400;
    return ms * int'(TB_HZ) / 1000;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp_drv, input logic exp_prot);
    checks++;
    if (drv_out !== exp_drv || prot_out !== exp_prot) begin
      failures++;
      $display("FAIL %s actual drv=%b prot=%b expected drv=%b prot=%b",
               tag, drv_out, prot_out, exp_drv, exp_prot);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    chk("R7 reset state", 4'b0000, 1'b0);
    rst_n = 1'b1;
    // R7: first window after reset, select 0
    wait_cyc(window(2'd0) - 8);
    chk("R7 still muted before window end sel0", 4'b0000, 1'b0);
    wait_cyc(16);
    chk("R7 running after window sel0", 4'b1111, 1'b0);

    for (int i = 0; i < NV; i++) begin
      mute_req = VEC[i][11];
      oc_flag  = VEC[i][10];
      ot_flag  = VEC[i][9];
      pwm_in   = VEC[i][8:5];
      wait_cyc(6);
      chk($sformatf("%s vector %0d", VTAG[i], i), VEC[i][4:1], VEC[i][0]);
    end
    mute_req = 0; oc_flag = 0; ot_flag = 0; pwm_in = 4'b1111;

    // R1: shutdown forces everything low and ignores faults
    sleep_req = 1; oc_flag = 1; ot_flag = 1;
    wait_cyc(8);
    chk("R1 shutdown with faults raised", 4'b0000, 1'b0);
    oc_flag = 0; ot_flag = 0; start_sel = 2'd1;
    wait_cyc(4);
    sleep_req = 0;
    // R9: glitches inside the wake-up window are not reported
    wait_cyc(100);
    ot_flag = 1; oc_flag = 1;
    wait_cyc(250);
    chk("R9 fault pulse inside window", 4'b0000, 1'b0);
    ot_flag = 0; oc_flag = 0;
    wait_cyc(window(2'd1) - 8 - 350);
    chk("R7 still muted before window end sel1", 4'b0000, 1'b0);
    wait_cyc(16);
    chk("R5 latch cleared by low-high-low shutdown", 4'b1111, 1'b0);

    // R8: supply fault mutes, then a full window runs again
    start_sel = 2'd2; supply_fault = 1;
    wait_cyc(8);
    chk("R8 supply fault mutes", 4'b0000, 1'b0);
    oc_flag = 1;
    wait_cyc(20);
    chk("R8 overcurrent ignored during supply fault", 4'b0000, 1'b0);
    oc_flag = 0;
    wait_cyc(4);
    supply_fault = 0;
    wait_cyc(window(2'd2) - 8);
    chk("R8 window rerun after supply fault", 4'b0000, 1'b0);
    wait_cyc(16);
    chk("R8 resumes after rerun window", 4'b1111, 1'b0);

    // R7: longest window
    sleep_req = 1; start_sel = 2'd3;
    wait_cyc(8);
    sleep_req = 0;
    wait_cyc(window(2'd3) - 8);
    chk("R7 still muted before window end sel3", 4'b0000, 1'b0);
    wait_cyc(16);
    chk("R7 running after window sel3", 4'b1111, 1'b0);

    // R6 and R1: thermal warning, then shutdown clears it
    ot_flag = 1;
    wait_cyc(8);
    chk("R6 thermal warning raised", 4'b1111, 1'b1);
    sleep_req = 1;
    wait_cyc(8);
    chk("R1 shutdown hides thermal warning", 4'b0000, 1'b0);
    ot_flag = 0; start_sel = 2'd0;
    wait_cyc(4);
    sleep_req = 0;
    wait_cyc(window(2'd0) + 8);
    chk("R6 no warning after wake", 4'b1111, 1'b0);

    // R5: reset clears a latched overcurrent warning
    oc_flag = 1;
    wait_cyc(8);
    oc_flag = 0;
    wait_cyc(8);
    chk("R5 overcurrent latched after flag drops", 4'b1111, 1'b1);
    rst_n = 0;
    wait_cyc(4);
    chk("R5 reset clears warning", 4'b0000, 1'b0);
    rst_n = 1;
    wait_cyc(window(2'd0) + 8);
    chk("R5 no warning after reset window", 4'b1111, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule